// File: doc/BRIEF.md
# Float Compare, Min/Max and Convert Unit

This unit handles the non-arithmetic operations of a 32-bit single-precision float pipe whose format has no infinities, no NaNs and no denormals. Each bit pattern stands for an ordinary signed-magnitude number. Exponent 255 is just a large exponent. Exponent 0 with a nonzero mantissa is still ordered by its raw bits.

On each cycle with `valid_i` high, the unit takes an operation code and two operands. One cycle later it presents the registered result. The available operations are:
- equal, less-than and less-or-equal compares, which drive a condition-bit write;
- minimum and maximum;
- a float-to-signed-integer conversion that truncates and saturates;
- absolute value and negation, which only touch the sign bit.

The condition bit is bit 23 of the surrounding control/status word. The unit drives the write enable and value for that bit, plus a strobe that tells the status logic to clear its overflow and underflow flags. Branching on the condition bit is handled elsewhere.

Top module: `flt_cmp_cvt`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first valid operation, `result_o`, `cond_we_o`, `cond_o` and `ou_clr_o` are all 0.
- R2: Operation codes are: EQ=0, LT=1, LE=2, MIN=3, MAX=4, CVT=5, ABS=6, NEG=7. For an EQ, LT or LE issued with `valid_i`, `cond_we_o` is 1 in the next cycle. In that cycle `cond_o` is 1 exactly when the relation a REL b holds, and `result_o` is 0. Operands are ordered as signed-magnitude numbers: bit 31 is the sign and bits 30:0 are the magnitude, with exponent 255 and exponent 0 included as ordinary values.
- R3: +0 (0x00000000) and -0 (0x80000000) compare equal: EQ and LE give 1, and LT gives 0, in either order.
- R4: MIN returns the smaller operand and MAX returns the larger one, under the R2 ordering. When the operands are equal, both return operand a bit-for-bit.
- R5: `ou_clr_o` is 1 in the cycle after a valid MIN, MAX, ABS or NEG. It is 0 after any other operation and after idle cycles.
- R6: CVT takes the value (1.mantissa)·2^(exp-127) with the sign of bit 31, where exp is bits 30:23 and the mantissa is bits 22:0. It truncates toward zero to a 32-bit two's-complement integer. An exponent below 127 gives 0.
- R7: CVT saturates when the magnitude is 2^31 or more, that is, when the exponent is 158 or above. The result is 0x7FFFFFFF for a positive input and 0x80000000 for a negative input.
- R8: ABS returns operand a with bit 31 cleared, and NEG returns operand a with bit 31 inverted. Operand b has no effect on either.
- R9: In the cycle after `valid_i` is low, `cond_we_o` and `ou_clr_o` are 0, and `result_o` and `cond_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (see R2) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result |
| cond_we_o | output | 1 | Condition-bit write enable |
| cond_o | output | 1 | Condition-bit value |
| ou_clr_o | output | 1 | Overflow/underflow flag clear strobe |

## Verification
The bench targets the cases listed below; each line says what a faulty design would do.
- **Signed zeros.** A plain bit compare would call +0 and -0 unequal.
- **Two negative operands.** A design that orders magnitudes without considering the sign would return the wrong operand for MIN and MAX.
- **Exponent 255 and exponent 0 with a nonzero mantissa.** A design that treats these as special would drop them out of the ordering.
- **Ties in MIN and MAX.** A design without the tie rule would return operand b.
- **Conversion at exponents 126, 127, 157 and 158.** These catch an off-by-one in the saturation threshold, a missing sign on the saturated value, and rounding where truncation is required.

// File: rtl/flt_unit_pkg.sv
`timescale 1ns/1ps
package flt_unit_pkg;
  typedef enum logic [2:0] {
    OP_EQ  = 3'd0,
    OP_LT  = 3'd1,
    OP_LE  = 3'd2,
    OP_MIN = 3'd3,
    OP_MAX = 3'd4,
    OP_CVT = 3'd5,
    OP_ABS = 3'd6,
    OP_NEG = 3'd7
  } fop_e;

  function automatic logic is_cmp(fop_e op);
    return (op == OP_EQ) || (op == OP_LT) || (op == OP_LE);
  endfunction

  function automatic logic is_ou_clr(fop_e op);
    return (op == OP_MIN) || (op == OP_MAX) || (op == OP_ABS) || (op == OP_NEG);
  endfunction
endpackage

// File: rtl/flt_order_cmp.sv
`timescale 1ns/1ps
module flt_order_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              lt_o,
  output logic              eq_o
);
  localparam int MAG_W = DATA_W - 1;

  logic             sa, sb, both_zero;
  logic [MAG_W-1:0] ma, mb;

  assign sa = a_i[DATA_W-1];
  assign sb = b_i[DATA_W-1];
  assign ma = a_i[MAG_W-1:0];
  assign mb = b_i[MAG_W-1:0];
  assign both_zero = ~|ma & ~|mb;

  assign eq_o = both_zero | (a_i == b_i);

  // sign decides first; same sign orders by magnitude, reversed when negative
  always_comb begin
    if (both_zero)    lt_o = 1'b0;
    else if (sa != sb) lt_o = sa;
    else if (sa)       lt_o = ma > mb;
    else               lt_o = ma < mb;
  end
endmodule

// File: rtl/flt_to_int.sv
`timescale 1ns/1ps
module flt_to_int #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] int_o
);
  localparam int MAN_W = DATA_W - 1 - EXP_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] MAN_V  = EXP_W'(MAN_W);
  localparam logic [EXP_W-1:0] SAT_V  = EXP_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] POS_SAT = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_SAT = {1'b1, {(DATA_W-1){1'b0}}};

  logic              sgn;
  logic [EXP_W-1:0]  ex, sh;
  logic [DATA_W-1:0] sig, mag;

  assign sgn = a_i[DATA_W-1];
  assign ex  = a_i[DATA_W-2 -: EXP_W];
  assign sig = DATA_W'({1'b1, a_i[MAN_W-1:0]});
  assign sh  = ex - BIAS_V;

  always_comb begin
    mag   = '0;
    int_o = '0;
    if (ex < BIAS_V) begin
      int_o = '0;
    end else if (sh >= SAT_V) begin
      int_o = sgn ? NEG_SAT : POS_SAT;
    end else begin
      if (sh >= MAN_V) mag = sig << (sh - MAN_V);
      else             mag = sig >> (MAN_V - sh);
      int_o = sgn ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/flt_cmp_cvt.sv
`timescale 1ns/1ps
module flt_cmp_cvt
  import flt_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              cond_we_o,
  output logic              cond_o,
  output logic              ou_clr_o
);
  localparam int SGN = DATA_W - 1;

  fop_e              op;
  logic              a_lt_b, a_eq_b, rel;
  logic [DATA_W-1:0] cvt_val, res_d;

  assign op = fop_e'(op_i);

  flt_order_cmp #(.DATA_W(DATA_W)) u_order (
    .a_i (a_i),
    .b_i (b_i),
    .lt_o(a_lt_b),
    .eq_o(a_eq_b)
  );

  flt_to_int #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cvt (
    .a_i  (a_i),
    .int_o(cvt_val)
  );

  always_comb begin
    rel   = 1'b0;
    res_d = '0;
    unique case (op)
      OP_EQ:  rel = a_eq_b;
      OP_LT:  rel = a_lt_b;
      OP_LE:  rel = a_lt_b | a_eq_b;
      OP_MIN: res_d = (a_lt_b | a_eq_b) ? a_i : b_i;
      OP_MAX: res_d = a_lt_b ? b_i : a_i;
      OP_CVT: res_d = cvt_val;
      OP_ABS: res_d = {1'b0, a_i[SGN-1:0]};
      OP_NEG: res_d = {~a_i[SGN], a_i[SGN-1:0]};
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      cond_we_o <= 1'b0;
      cond_o    <= 1'b0;
      ou_clr_o  <= 1'b0;
    end else if (valid_i) begin
      result_o  <= res_d;
      cond_we_o <= is_cmp(op);
      cond_o    <= is_cmp(op) ? rel : cond_o;
      ou_clr_o  <= is_ou_clr(op);
    end else begin
      cond_we_o <= 1'b0;
      ou_clr_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/flt_cmp_cvt_chk.sv
`timescale 1ns/1ps
module flt_cmp_cvt_chk #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] result_o,
  input logic              cond_we_o,
  input logic              cond_o,
  input logic              ou_clr_o
);
  localparam int SAT_EXP = (1 << (EXP_W - 1)) - 1 + DATA_W - 1;

  logic cmp_in, clr_in, sat_in;
  assign cmp_in = valid_i && (op_i <= 3'd2);
  assign clr_in = valid_i && (op_i == 3'd3 || op_i == 3'd4 || op_i >= 3'd6);
  assign sat_in = valid_i && (op_i == 3'd5) && (int'(a_i[DATA_W-2 -: EXP_W]) >= SAT_EXP);

  assert_cond_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_in |=> cond_we_o && result_o == '0);

  assert_ou_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (ou_clr_o == $past(clr_in)));

  assert_strobes_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cond_we_o && ou_clr_o));

  assert_minmax_operand_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd3 || op_i == 3'd4)) |=>
      (result_o == $past(a_i) || result_o == $past(b_i)));

  assert_abs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6) |=> result_o == {1'b0, $past(a_i[DATA_W-2:0])});

  assert_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_in |=> result_o == ($past(a_i[DATA_W-1]) ? {1'b1, {(DATA_W-1){1'b0}}}
                                                 : {1'b0, {(DATA_W-1){1'b1}}}));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !cond_we_o && !ou_clr_o && $stable(result_o) && $stable(cond_o));
endmodule

bind flt_cmp_cvt flt_cmp_cvt_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .cond_we_o(cond_we_o),
  .cond_o   (cond_o),
  .ou_clr_o (ou_clr_o)
);

// File: tb/tb_flt_cmp_cvt.sv
`timescale 1ns/1ps
module tb_flt_cmp_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic        cond_we, cond, ou_clr;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  flt_cmp_cvt dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .b_i(b), .result_o(result), .cond_we_o(cond_we),
    .cond_o(cond), .ou_clr_o(ou_clr)
  );

  // ---------------- behavioural reference ----------------
  function automatic longint key(logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic logic [31:0] cvt_ref(logic [31:0] x);
    real v, av;
    int  e;
    e  = int'(x[30:23]);
    v  = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    av = v;
    if (av >= 2147483648.0) return x[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    return x[31] ? -32'($rtoi(av)) : 32'($rtoi(av));
  endfunction

  logic [31:0] m_res;
  logic        m_we, m_cond, m_clr, m_valid;
  logic [2:0]  m_op;
  logic [31:0] m_a, m_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res <= '0; m_we <= 0; m_cond <= 0; m_clr <= 0; m_valid <= 0;
      m_op <= '0; m_a <= '0; m_b <= '0;
    end else begin
      m_valid <= valid; m_op <= op; m_a <= a; m_b <= b;
      if (valid) begin
        m_we  <= (op <= 3'd2);
        m_clr <= (op == 3'd3 || op == 3'd4 || op == 3'd6 || op == 3'd7);
        case (op)
          3'd0: begin m_cond <= key(a) == key(b); m_res <= '0; end
          3'd1: begin m_cond <= key(a) <  key(b); m_res <= '0; end
          3'd2: begin m_cond <= key(a) <= key(b); m_res <= '0; end
          3'd3: m_res <= (key(b) < key(a)) ? b : a;
          3'd4: m_res <= (key(b) > key(a)) ? b : a;
          3'd5: m_res <= cvt_ref(a);
          3'd6: m_res <= a & 32'h7FFF_FFFF;
          default: m_res <= a ^ 32'h8000_0000;
        endcase
      end else begin
        m_we <= 0; m_clr <= 0;
      end
    end
  end

  function automatic string tag_of();
    if (!m_valid) return "R9";
    case (m_op)
      3'd0, 3'd1, 3'd2: return (m_a[30:0] == 0 && m_b[30:0] == 0) ? "R3" : "R2";
      3'd3, 3'd4: return "R4";
      3'd5: return (int'(m_a[30:23]) >= 158) ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check_outputs(string forced_tag);
    string t = (forced_tag != "") ? forced_tag : tag_of();
    checks++;
    if (result !== m_res || cond_we !== m_we || cond !== m_cond) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h: result=%h we=%0b cond=%0b expected result=%h we=%0b cond=%0b",
               t, m_op, m_a, m_b, result, cond_we, cond, m_res, m_we, m_cond);
    end
    checks++;
    if (ou_clr !== m_clr) begin
      failures++;
      $display("FAIL R5 op=%0d: ou_clr=%0b expected %0b", m_op, ou_clr, m_clr);
    end
  endtask

  task automatic issue(logic v, logic [2:0] o, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    check_outputs("");
    valid = v; op = o; a = x; b = y;
  endtask

  function automatic logic [31:0] rnd_flt();
    int sel = $urandom_range(0, 9);
    logic [7:0] e;
    case (sel)
      0: e = 8'd0;   1: e = 8'd255; 2: e = 8'd126; 3: e = 8'd127;
      4: e = 8'd157; 5: e = 8'd158; 6: e = 8'd150;
      default: e = 8'($urandom);
    endcase
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R1"); // reset held
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1"); // released, nothing issued

    // R3: signed zeros
    issue(1, 3'd0, 32'h0000_0000, 32'h8000_0000);
    issue(1, 3'd1, 32'h8000_0000, 32'h0000_0000);
    issue(1, 3'd2, 32'h0000_0000, 32'h8000_0000);
    issue(1, 3'd3, 32'h8000_0000, 32'h0000_0000); // R4 tie -> a
    issue(1, 3'd4, 32'h0000_0000, 32'h8000_0000); // R4 tie -> a
    // R2: both negative, exponent 255, exponent 0 nonzero mantissa
    issue(1, 3'd1, 32'hC000_0000, 32'hBF80_0000);
    issue(1, 3'd1, 32'h7F80_0000, 32'h7FFF_FFFF);
    issue(1, 3'd2, 32'h0000_0001, 32'h0000_0000);
    issue(1, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R4: negative operands
    issue(1, 3'd3, 32'hC000_0000, 32'hBF80_0000);
    issue(1, 3'd4, 32'hC000_0000, 32'hBF80_0000);
    // R6/R7 conversion boundaries
    issue(1, 3'd5, 32'h3F7F_FFFF, 32'h0);  // 0.99.. -> 0
    issue(1, 3'd5, 32'hBFC0_0000, 32'h0);  // -1.5 -> -1
    issue(1, 3'd5, 32'h4EFF_FFFF, 32'h0);  // exp 157 max
    issue(1, 3'd5, 32'h4F00_0000, 32'h0);  // 2^31 -> saturate
    issue(1, 3'd5, 32'hCF00_0000, 32'h0);  // -2^31
    issue(1, 3'd5, 32'hFFFF_FFFF, 32'h0);  // exp 255 negative
    // R8 with b varied
    issue(1, 3'd6, 32'h8123_4567, 32'hFFFF_FFFF);
    issue(1, 3'd7, 32'h0123_4567, 32'h1234_5678);
    issue(1, 3'd7, 32'h8000_0000, 32'h0);
    // R9 idle with junk inputs
    issue(0, 3'd3, 32'h1234_5678, 32'h8765_4321);
    issue(0, 3'd0, 32'h0, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x = rnd_flt();
      logic [31:0] y = ($urandom_range(0, 7) == 0) ? x : rnd_flt();
      issue(1'($urandom_range(0, 5) != 0), 3'($urandom), x, y);
    end
    issue(0, 3'd0, 32'h0, 32'h0);
    @(negedge clk);
    check_outputs("");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule